// File: doc/BRIEF.md
# ECC Memory Termination Generator

This block sits on the slave side of a RAM that is guarded by an error checker. When the bus master opens a read by raising its strobe, the block decides how and when the cycle is terminated. It drives three signals back toward the master: an acknowledge, a bus error and a halt. A two-bit policy input chooses between two acknowledge timings and two reporting styles. Under delayed acknowledge the block waits for the checker's verdict before it answers. Under early acknowledge it answers at once and raises an error afterwards if the data turns out bad. A bad read is reported either as a plain bus error, which leads the master into exception handling, or as bus error together with halt, which asks the master to retry.

The checker's verdict is sampled a fixed number of clocks after the read starts; that number is a parameter. Under a retry policy, halt stays asserted while the memory controller repairs the failing location. The repair logic reports completion on a separate input, and halt then drops so that the master can repeat the access. Acknowledge and bus error follow the strobe: they fall on the clock after the master lets go of it. The syndrome logic and the RAM array are not part of this block.

Top module: `ecc_term_ctrl`

## Requirements
- R1: While reset is held, and on the first clock after it, acknowledge, bus error and halt are all low.
- R2: The policy code is taken on the clock where the read starts: bit 1 set selects early acknowledge, bit 0 set selects retry reporting (00 delayed/exception, 01 delayed/retry, 10 early/exception, 11 early/retry). Later changes to the code have no effect on that read.
- R3: Under early acknowledge, acknowledge is high from the first clock edge that samples the strobe high, whatever the check latency is.
- R4: Under delayed acknowledge, acknowledge stays low until the check point, CHK_LAT clocks after the start edge. A clean result then raises acknowledge on that edge.
- R5: A bad result under an exception policy raises bus error at the check point without halt. The delayed policy gives no acknowledge, and the early policy keeps its acknowledge.
- R6: A bad result under a retry policy raises bus error and halt together at the check point. The delayed policy gives no acknowledge.
- R7: The error input is looked at only on the check-point edge; its value on the other clocks of the read has no effect.
- R8: Halt, once raised, stays high until an edge samples the repair-done input high, and it falls on that edge, whether or not the strobe is still high.
- R9: A low strobe clears acknowledge and bus error on the next edge. A read abandoned before its check point raises neither bus error nor halt.
- R10: No new read starts while halt is high. A strobe held high across the halt starts a read on the edge after halt falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_sel | input | 2 | Termination policy code (bit 1 early acknowledge, bit 0 retry) |
| rd_stb | input | 1 | Read strobe from the bus master |
| chk_err | input | 1 | Checker verdict, high means the data is bad |
| fix_done | input | 1 | Repair of the failing location is complete |
| bus_ack | output | 1 | Cycle acknowledge |
| bus_berr | output | 1 | Bus error |
| bus_halt | output | 1 | Halt, held during repair |

## Verification
The hardest case to reach is a strobe that is already high while halt is still held from the previous bad read. The read must not start then, and it must start exactly one edge after the repair-done pulse. The bench creates this case directly: it ends a retry-policy read, raises the strobe again while halt is held, and waits several clocks. It then pulses repair-done and checks that acknowledge arrives on the following edge. Directed reads also cover a policy code changed in mid-read, an error input that falls just before the check point, a read abandoned before its verdict, and repair finishing while the strobe is still high.

// File: rtl/ecc_term_pkg.sv
package ecc_term_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_TERM  = 2'd2
  } term_st_e;

  typedef struct packed {
    logic early;
    logic retry;
  } term_pol_s;

  // bit 1 of the code picks early acknowledge, bit 0 picks retry reporting
  function automatic term_pol_s decode_pol(input logic [1:0] code);
    term_pol_s r;
    r.early = code[1];
    r.retry = code[0];
    return r;
  endfunction

  // acknowledge level after the verdict is known
  function automatic logic ack_after_check(input term_pol_s p, input logic bad);
    return p.early | ~bad;
  endfunction

  // halt request after the verdict is known
  function automatic logic halt_after_check(input term_pol_s p, input logic bad);
    return bad & p.retry;
  endfunction

endpackage

// File: rtl/ecc_chk_timer.sv
module ecc_chk_timer #(
  parameter int CHK_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic at_check
);
  localparam int CW = $clog2(CHK_LAT + 1);
  localparam logic [CW-1:0] LAT_W = CW'(CHK_LAT);
  localparam logic [CW-1:0] ONE_W = CW'(1);

  logic [CW-1:0] cnt_q;

  assign at_check = run && (cnt_q == LAT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= ONE_W;
    end else if (run && (cnt_q != LAT_W)) begin
      cnt_q <= cnt_q + ONE_W;
    end
  end

  // the verdict is taken once per read
  assert_single_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
    at_check |=> !at_check);

endmodule

// File: rtl/ecc_halt_hold.sv
module ecc_halt_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic fix_done,
  output logic halt
);
  logic halt_q;

  assign halt = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (set) begin
      halt_q <= 1'b1;
    end else if (fix_done) begin
      halt_q <= 1'b0;
    end
  end

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !fix_done) |=> halt);

  assert_halt_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && fix_done && !set) |=> !halt);

endmodule

// File: rtl/ecc_term_fsm.sv
module ecc_term_fsm
  import ecc_term_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic [1:0] pol_code,
  input  logic       chk_err,
  input  logic       at_check,
  input  logic       halt,
  output logic       cyc_start,
  output logic       in_check,
  output logic       halt_set,
  output logic       ack,
  output logic       berr
);
  term_st_e  st_q, st_d;
  term_pol_s pol_q;
  logic      ack_q, berr_q;
  logic      check_hit, bad_hit;

  assign cyc_start = (st_q == ST_IDLE) && strobe && !halt;
  assign in_check  = (st_q == ST_CHECK);
  assign check_hit = in_check && strobe && at_check;
  assign bad_hit   = check_hit && chk_err;
  assign halt_set  = check_hit && halt_after_check(pol_q, chk_err);
  assign ack       = ack_q;
  assign berr      = berr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (cyc_start) st_d = ST_CHECK;
      ST_CHECK: if (!strobe) st_d = ST_IDLE;
                else if (at_check) st_d = ST_TERM;
      ST_TERM:  if (!strobe) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pol_q  <= '0;
      ack_q  <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cyc_start) pol_q <= decode_pol(pol_code);
      if (!strobe) begin
        ack_q  <= 1'b0;
        berr_q <= 1'b0;
      end else begin
        if (cyc_start) ack_q <= decode_pol(pol_code).early;
        else if (check_hit) ack_q <= ack_after_check(pol_q, chk_err);
        if (bad_hit) berr_q <= 1'b1;
      end
    end
  end

  assert_early_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && pol_code[1]) |=> ack);

  assert_delayed_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && !pol_q.early) |-> !ack);

  assert_bad_berr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_hit |=> berr);

  assert_strobe_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (!ack && !berr));

endmodule

// File: rtl/ecc_term_ctrl.sv
module ecc_term_ctrl #(
  parameter int CHK_LAT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pol_sel,
  input  logic       rd_stb,
  input  logic       chk_err,
  input  logic       fix_done,
  output logic       bus_ack,
  output logic       bus_berr,
  output logic       bus_halt
);
  logic cyc_start, in_check, at_check, halt_set;

  ecc_chk_timer #(.CHK_LAT(CHK_LAT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cyc_start),
    .run      (in_check),
    .at_check (at_check)
  );

  ecc_term_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (rd_stb),
    .pol_code  (pol_sel),
    .chk_err   (chk_err),
    .at_check  (at_check),
    .halt      (bus_halt),
    .cyc_start (cyc_start),
    .in_check  (in_check),
    .halt_set  (halt_set),
    .ack       (bus_ack),
    .berr      (bus_berr)
  );

  ecc_halt_hold u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (halt_set),
    .fix_done (fix_done),
    .halt     (bus_halt)
  );

  assert_halt_berr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_halt) |-> bus_berr);

  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_halt && !bus_ack) |=> !bus_ack);

endmodule

// File: tb/sim_ecc_term_ctrl.sv
module sim_ecc_term_ctrl;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pol = 2'b00;
  logic stb = 1'b0, err = 1'b0, fix = 1'b0;
  logic ack, berr, halt;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ecc_term_ctrl #(.CHK_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol), .rd_stb(stb),
    .chk_err(err), .fix_done(fix),
    .bus_ack(ack), .bus_berr(berr), .bus_halt(halt)
  );

  // fields: [6:5] policy, [4] error, [3] ack before verdict,
  //         [2] ack after verdict, [1] berr after, [0] halt after
  localparam logic [6:0] VEC [0:7] = '{
    7'b00_0_0_1_0_0, 7'b00_1_0_0_1_0,
    7'b01_0_0_1_0_0, 7'b01_1_0_0_1_1,
    7'b10_0_1_1_0_0, 7'b10_1_1_1_1_0,
    7'b11_0_1_1_0_0, 7'b11_1_1_1_1_1
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_fix;
    fix = 1'b1;
    tick();
    fix = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    chk("R1 ack in reset", ack, 1'b0);
    chk("R1 berr in reset", berr, 1'b0);
    chk("R1 halt in reset", halt, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1 ack after reset", ack, 1'b0);

    // table walk: every policy with clean and bad data (R3 R4 R5 R6)
    for (int i = 0; i < 8; i++) begin
      pol = VEC[i][6:5];
      err = VEC[i][4];
      stb = 1'b1;
      for (int j = 0; j < LAT; j++) begin
        tick();
        chk($sformatf("R3/R4 ack before verdict v%0d e%0d", i, j), ack, VEC[i][3]);
        chk($sformatf("R4 berr before verdict v%0d", i), berr, 1'b0);
      end
      tick();
      chk($sformatf("R4/R5 ack at verdict v%0d", i), ack, VEC[i][2]);
      chk($sformatf("R5/R6 berr at verdict v%0d", i), berr, VEC[i][1]);
      chk($sformatf("R6 halt at verdict v%0d", i), halt, VEC[i][0]);
      stb = 1'b0;
      tick();
      chk($sformatf("R9 ack cleared v%0d", i), ack, 1'b0);
      chk($sformatf("R9 berr cleared v%0d", i), berr, 1'b0);
      chk($sformatf("R8 halt kept after strobe v%0d", i), halt, VEC[i][0]);
      if (VEC[i][0]) begin
        tick();
        chk("R8 halt held without repair", halt, 1'b1);
        pulse_fix();
        chk("R8 halt dropped on repair", halt, 1'b0);
      end
      tick();
    end

    // R2: code changed in mid-read from early/retry to delayed/exception
    pol = 2'b11; err = 1'b1; stb = 1'b1;
    tick();
    chk("R2 early ack from latched code", ack, 1'b1);
    pol = 2'b00;
    repeat (LAT - 1) tick();
    tick();
    chk("R2 ack kept under latched code", ack, 1'b1);
    chk("R2 halt from latched code", halt, 1'b1);
    stb = 1'b0;
    tick();
    pulse_fix();
    chk("R2 halt repaired", halt, 1'b0);

    // R7: error high until just before the verdict edge
    pol = 2'b00; err = 1'b1; stb = 1'b1;
    repeat (LAT) tick();
    err = 1'b0;
    tick();
    chk("R7 clean verdict ack", ack, 1'b1);
    chk("R7 clean verdict berr", berr, 1'b0);
    err = 1'b1;
    tick();
    chk("R7 late error ignored", berr, 1'b0);
    stb = 1'b0; err = 1'b0;
    tick();

    // R9: read abandoned before its verdict
    pol = 2'b01; err = 1'b1; stb = 1'b1;
    repeat (2) tick();
    stb = 1'b0;
    repeat (LAT + 1) tick();
    chk("R9 abandoned read berr", berr, 1'b0);
    chk("R9 abandoned read halt", halt, 1'b0);
    chk("R9 abandoned read ack", ack, 1'b0);

    // R8: repair ends while the strobe is still high
    pol = 2'b01; err = 1'b1; stb = 1'b1;
    repeat (LAT + 1) tick();
    chk("R8 halt up", halt, 1'b1);
    pulse_fix();
    chk("R8 halt down with strobe high", halt, 1'b0);
    chk("R8 berr still up", berr, 1'b1);
    stb = 1'b0; err = 1'b0;
    tick();

    // R10: strobe raised while halt still held
    pol = 2'b11; err = 1'b1; stb = 1'b1;
    repeat (LAT + 1) tick();
    stb = 1'b0;
    tick();
    pol = 2'b10; err = 1'b0; stb = 1'b1;
    repeat (4) tick();
    chk("R10 no start under halt", ack, 1'b0);
    pulse_fix();
    chk("R10 halt dropped", halt, 1'b0);
    chk("R10 no ack on repair edge", ack, 1'b0);
    tick();
    chk("R10 start after halt", ack, 1'b1);
    repeat (LAT) tick();
    chk("R10 resumed read clean", berr, 1'b0);
    stb = 1'b0;
    tick();
    chk("R10 resumed read closed", ack, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule